// File: doc/BRIEF.md
# Cascadable Universal Counter with Look-Ahead Carry

This block is a synchronous up/down counter of parameterizable width (six bits by default). A two-bit mode input selects one of four operations on each rising clock edge: parallel preset, count up, count down, or hold. Counting in either direction needs two enables, both active low. The first is a carry-in. The second is a look-ahead-carry-in, which the block captures in a flip-flop on every edge before it combines it with the carry-in.

The block gives two active-low carry signals. The carry-out goes low while the count sits at terminal count: all ones when counting up, all zeros when counting down. The look-ahead-carry-out is a one-cycle low pulse that comes out one count ahead of terminal count.

Several stages chain into a wide counter without extra gates. The least significant stage runs with its carry-in held low. Every stage above it takes its carry-in from the carry-out of the stage just below. All the upper stages take their look-ahead-carry-in from the look-ahead-carry-out of the least significant stage. The carry ripple through the upper stages then has a whole counter period to settle. The only path that has to meet single-cycle timing is the registered look-ahead signal. An active-high master reset acts asynchronously. It clears the count and sets every carry flip-flop to its inactive state.

Top module: `cascade_counter`

## Requirements
- R1: Mode encoding is fixed: mode 2'b00 is preset load, 2'b01 count up, 2'b10 count down, 2'b11 hold.
- R2: A count step (up or down, modulo 2^WIDTH) happens on an edge only when cin_n is 0 and the look-ahead-carry-in value registered on the previous edge is 0; otherwise q keeps its value.
- R3: In load mode q takes the value of data on the next rising edge, whatever cin_n and lacin_n are.
- R4: In hold mode q does not change.
- R5: A terminal flag is registered on each edge, set when the edge leaves a count mode with q at all ones (up) or all zeros (down). cout_n is low exactly while that flag is set and cin_n is 0. A freely counting stage therefore shows a one-cycle low pulse.
- R6: lacout_n is a register. It goes low for one cycle after an enabled count edge that makes q equal to all ones minus one (up) or to one (down).
- R7: After a load or hold edge, cout_n and lacout_n are both high. Loading a terminal value therefore never drives cout_n low.
- R8: cout_p is always the complement of cout_n.
- R9: While rst is high, q is zero at once, without waiting for a clock edge. cout_n and lacout_n are high, and the look-ahead-carry-in register holds 1, so the first edge after release does not count.
- R10: Four stages chained as described above behave as one 24-bit up/down counter, including carries across every stage boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous active-high master reset |
| mode | input | 2 | Operation select (R1 encoding) |
| data | input | WIDTH | Preset value |
| cin_n | input | 1 | Active-low carry-in |
| lacin_n | input | 1 | Active-low look-ahead-carry-in, registered inside |
| q | output | WIDTH | Current count |
| cout_n | output | 1 | Active-low carry-out |
| cout_p | output | 1 | Complement of cout_n |
| lacout_n | output | 1 | Active-low registered look-ahead-carry-out |

## Verification
Two functions can land on the same edge. One is the carry into the upper stages, which fires when the low stage wraps. The other is a stall, which happens when the carry-in or the registered look-ahead input is high. The bench provokes both on a four-stage chain. It stalls the chain with carry-in high, and separately with the look-ahead-in high for one cycle, which stalls it one edge later. It then lets the low stage wrap into the upper stages in both directions. A scoreboard compares every cycle's 24-bit value against an independent model of the enable register. Directed checks judge the carry pulses exactly on the edges where terminal and pre-terminal values are reached.

// File: rtl/ucnt_pkg.sv
package ucnt_pkg;
  typedef enum logic [1:0] {
    M_LOAD = 2'b00,
    M_UP   = 2'b01,
    M_DOWN = 2'b10,
    M_HOLD = 2'b11
  } mode_e;
endpackage

// File: rtl/ucnt_mode_dec.sv
// Mode decoding and the registered look-ahead-carry-in enable.
module ucnt_mode_dec (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       cin_n,
  input  logic       lacin_n,
  output logic       do_load,
  output logic       sel_up,
  output logic       sel_down,
  output logic       step_up,
  output logic       step_down
);
  import ucnt_pkg::*;

  logic  lac_q;
  logic  step_ok;
  mode_e m;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) lac_q <= 1'b1;
    else     lac_q <= lacin_n;
  end

  assign step_ok = ~(cin_n | lac_q);
  assign m       = mode_e'(mode);

  always_comb begin
    do_load  = 1'b0;
    sel_up   = 1'b0;
    sel_down = 1'b0;
    unique case (m)
      M_LOAD: do_load  = 1'b1;
      M_UP:   sel_up   = 1'b1;
      M_DOWN: sel_down = 1'b1;
      default: ;
    endcase
  end

  assign step_up   = sel_up & step_ok;
  assign step_down = sel_down & step_ok;
endmodule

// File: rtl/ucnt_count_reg.sv
// Count register with its next-state computation.
module ucnt_count_reg #(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             do_load,
  input  logic             step_up,
  input  logic             step_down,
  input  logic [WIDTH-1:0] data,
  output logic [WIDTH-1:0] q_next,
  output logic [WIDTH-1:0] q
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_comb begin
    if (do_load)        q_next = data;
    else if (step_up)   q_next = q + ONE;
    else if (step_down) q_next = q - ONE;
    else                q_next = q;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) q <= '0;
    else     q <= q_next;
  end
endmodule

// File: rtl/ucnt_carry_gen.sv
// Registered terminal and look-ahead flags, carry-in gating for cascades.
module ucnt_carry_gen #(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_up,
  input  logic             sel_down,
  input  logic             step_up,
  input  logic             step_down,
  input  logic             cin_n,
  input  logic [WIDTH-1:0] q_next,
  output logic             cout_n,
  output logic             cout_p,
  output logic             lacout_n
);
  localparam logic [WIDTH-1:0] TOP    = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] PRE_UP = TOP - WIDTH'(1);
  localparam logic [WIDTH-1:0] PRE_DN = WIDTH'(1);

  logic tc_q;
  logic tc_next;
  logic lac_next;

  assign tc_next  = (sel_up & (q_next == TOP)) | (sel_down & (q_next == '0));
  assign lac_next = (step_up & (q_next == PRE_UP)) | (step_down & (q_next == PRE_DN));

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      tc_q     <= 1'b0;
      lacout_n <= 1'b1;
    end else begin
      tc_q     <= tc_next;
      lacout_n <= ~lac_next;
    end
  end

  assign cout_p = tc_q & ~cin_n;
  assign cout_n = ~cout_p;
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter #(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] data,
  input  logic             cin_n,
  input  logic             lacin_n,
  output logic [WIDTH-1:0] q,
  output logic             cout_n,
  output logic             cout_p,
  output logic             lacout_n
);
  logic             do_load, sel_up, sel_down, step_up, step_down;
  logic [WIDTH-1:0] q_next;

  ucnt_mode_dec u_dec (
    .clk(clk), .rst(rst), .mode(mode), .cin_n(cin_n), .lacin_n(lacin_n),
    .do_load(do_load), .sel_up(sel_up), .sel_down(sel_down),
    .step_up(step_up), .step_down(step_down)
  );

  ucnt_count_reg #(.WIDTH(WIDTH)) u_cnt (
    .clk(clk), .rst(rst), .do_load(do_load), .step_up(step_up),
    .step_down(step_down), .data(data), .q_next(q_next), .q(q)
  );

  ucnt_carry_gen #(.WIDTH(WIDTH)) u_car (
    .clk(clk), .rst(rst), .sel_up(sel_up), .sel_down(sel_down),
    .step_up(step_up), .step_down(step_down), .cin_n(cin_n),
    .q_next(q_next), .cout_n(cout_n), .cout_p(cout_p), .lacout_n(lacout_n)
  );
endmodule

// File: rtl/ucnt_checker.sv
module ucnt_checker #(
  parameter int WIDTH = 6
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode,
  input logic [WIDTH-1:0] data,
  input logic             cin_n,
  input logic [WIDTH-1:0] q,
  input logic             cout_n,
  input logic             lacout_n
);
  assert_load_takes_data_R3: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00) |=> (q == $past(data)));

  assert_hold_keeps_count_R4: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11) |=> $stable(q));

  assert_cin_blocks_step_R2: assert property (@(posedge clk) disable iff (rst)
    (mode[1] != mode[0] && cin_n) |=> $stable(q));

  assert_carries_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00 || mode == 2'b11) |=> (cout_n && lacout_n));

  assert_lac_single_R6: assert property (@(posedge clk) disable iff (rst)
    !lacout_n |=> lacout_n);

  assert_cout_at_terminal_R5: assert property (@(posedge clk) disable iff (rst)
    !cout_n |-> (q == '1 || q == '0));
endmodule

bind cascade_counter ucnt_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .data(data), .cin_n(cin_n),
  .q(q), .cout_n(cout_n), .lacout_n(lacout_n)
);

// File: tb/sim_cascade_counter.sv
module sim_cascade_counter;
  localparam int CLK_PERIOD = 10;
  localparam int W   = 6;
  localparam int TOT = 4 * W;
  localparam logic [1:0] LD = 2'b00, UP = 2'b01, DN = 2'b10, HD = 2'b11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode = HD;
  logic [TOT-1:0] din = '0;
  logic lsb_cin_n = 1'b0;
  logic lsb_lac_n = 1'b0;

  logic [W-1:0] q0, q1, q2, q3;
  logic c0, c1, c2, c3, p0, p1, p2, p3, l0, l1, l2, l3;
  wire  [TOT-1:0] qall = {q3, q2, q1, q0};

  always #(CLK_PERIOD/2) clk = ~clk;

  cascade_counter #(.WIDTH(W)) u0 (.clk(clk), .rst(rst), .mode(mode), .data(din[5:0]),
    .cin_n(lsb_cin_n), .lacin_n(lsb_lac_n), .q(q0), .cout_n(c0), .cout_p(p0), .lacout_n(l0));
  cascade_counter #(.WIDTH(W)) u1 (.clk(clk), .rst(rst), .mode(mode), .data(din[11:6]),
    .cin_n(c0), .lacin_n(l0), .q(q1), .cout_n(c1), .cout_p(p1), .lacout_n(l1));
  cascade_counter #(.WIDTH(W)) u2 (.clk(clk), .rst(rst), .mode(mode), .data(din[17:12]),
    .cin_n(c1), .lacin_n(l0), .q(q2), .cout_n(c2), .cout_p(p2), .lacout_n(l2));
  cascade_counter #(.WIDTH(W)) u3 (.clk(clk), .rst(rst), .mode(mode), .data(din[23:18]),
    .cin_n(c2), .lacin_n(l0), .q(q3), .cout_n(c3), .cout_p(p3), .lacout_n(l3));

  int n_chk = 0;
  int n_fail = 0;
  logic [TOT-1:0] sb[$];
  logic [TOT-1:0] ref_cnt = '0;
  logic lac_m = 1'b1;
  bit mon_on = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: sets inputs for the next edge and queues the expected count.
  task automatic cyc(input logic [1:0] m, input logic [TOT-1:0] d,
                     input logic ci, input logic la);
    logic en;
    @(negedge clk);
    rst = 1'b0;
    mode = m; din = d; lsb_cin_n = ci; lsb_lac_n = la;
    en = !(ci | lac_m);
    lac_m = la;
    case (m)
      LD: ref_cnt = d;
      UP: if (en) ref_cnt = ref_cnt + 1'b1;
      DN: if (en) ref_cnt = ref_cnt - 1'b1;
      default: ;
    endcase
    sb.push_back(ref_cnt);
  endtask

  task automatic after_edge();
    @(posedge clk);
    #2;
  endtask

  // Monitor: pops one expected value per edge.
  always @(posedge clk) begin
    #2;
    if (mon_on && sb.size() > 0) begin
      logic [TOT-1:0] e;
      e = sb.pop_front();
      check("R10 chain count", 32'(qall), 32'(e));
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R9 reset count", 32'(qall), 32'(0));
    check("R9 reset cout", 32'(c0), 32'(1));
    check("R8 reset cout_p", 32'(p0), 32'(0));
    check("R9 reset lacout", 32'(l0), 32'(1));

    mon_on = 1'b1;
    cyc(UP, '0, 1'b0, 1'b0); after_edge();
    check("R9 first edge blocked", 32'(qall), 32'(0));
    for (int i = 0; i < 3; i++) cyc(UP, '0, 1'b0, 1'b0);

    // R3: load with cin high still loads; R7 carries stay high
    cyc(LD, {6'd63, 6'd63, 6'd63, 6'd60}, 1'b1, 1'b0); after_edge();
    check("R3 load ignores cin", 32'(qall), 32'hFFFFFC);
    check("R7 load cout", 32'(c0), 32'(1));
    check("R7 load lacout", 32'(l0), 32'(1));
    cyc(UP, '0, 1'b0, 1'b0);
    cyc(UP, '0, 1'b0, 1'b0); after_edge();
    check("R6 up lacout low at 62", 32'(l0), 32'(0));
    check("R5 cout high at 62", 32'(c0), 32'(1));
    cyc(UP, '0, 1'b0, 1'b0); after_edge();
    check("R5 up cout low at 63", 32'(c0), 32'(0));
    check("R8 cout_p high", 32'(p0), 32'(1));
    check("R6 lacout single pulse", 32'(l0), 32'(1));
    check("R10 top stage carry ready", 32'(c3), 32'(0));
    cyc(UP, '0, 1'b0, 1'b0); after_edge();
    check("R5 cout released after wrap", 32'(c0), 32'(1));
    for (int i = 0; i < 3; i++) cyc(UP, '0, 1'b0, 1'b0);

    // Down direction
    cyc(LD, {6'd0, 6'd0, 6'd0, 6'd3}, 1'b0, 1'b0);
    cyc(DN, '0, 1'b0, 1'b0);
    cyc(DN, '0, 1'b0, 1'b0); after_edge();
    check("R6 down lacout low at 1", 32'(l0), 32'(0));
    cyc(DN, '0, 1'b0, 1'b0); after_edge();
    check("R5 down cout low at 0", 32'(c0), 32'(0));
    cyc(DN, '0, 1'b0, 1'b0); after_edge();
    check("R10 down borrow across stages", 32'(qall), 32'hFFFFFF);

    // Hold
    cyc(HD, '0, 1'b0, 1'b0);
    cyc(HD, '0, 1'b0, 1'b0); after_edge();
    check("R4 hold keeps count", 32'(qall), 32'hFFFFFF);
    check("R7 hold cout", 32'(c0), 32'(1));
    check("R1 hold encoding lacout", 32'(l0), 32'(1));

    // Loading terminal value must not pull cout low
    cyc(LD, {6'd0, 6'd0, 6'd0, 6'd63}, 1'b0, 1'b0); after_edge();
    check("R7 loaded terminal cout", 32'(c0), 32'(1));
    check("R8 loaded terminal cout_p", 32'(p0), 32'(0));

    // Enable gating
    cyc(LD, {6'd5, 6'd63, 6'd63, 6'd50}, 1'b0, 1'b0);
    cyc(UP, '0, 1'b0, 1'b0);
    cyc(UP, '0, 1'b1, 1'b0); after_edge();
    check("R2 cin high stalls", 32'(q0), 32'(51));
    cyc(UP, '0, 1'b0, 1'b0);
    cyc(UP, '0, 1'b0, 1'b1); after_edge();
    check("R2 lacin high not yet seen", 32'(q0), 32'(53));
    cyc(UP, '0, 1'b0, 1'b0); after_edge();
    check("R2 registered lacin stalls", 32'(q0), 32'(53));
    for (int i = 0; i < 14; i++) cyc(UP, '0, 1'b0, 1'b0);
    after_edge();
    check("R10 carry into third stage", 32'(qall), 32'h180003);

    // Asynchronous reset mid-cycle
    mon_on = 1'b0;
    sb.delete();
    @(negedge clk);
    #1 rst = 1'b1;
    #1;
    check("R9 async clear", 32'(qall), 32'(0));
    check("R9 async cout", 32'(c0), 32'(1));
    check("R9 async lacout", 32'(l0), 32'(1));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule